// File: doc/BRIEF.md
# DRAM Row-Buffer State Classifier

This block follows the open-row state of every bank behind one memory controller. It places each incoming request in one of three classes. A hit finds its row already in the bank's row buffer. A miss finds the bank precharged with nothing open. A conflict finds a different row still open, which must be precharged before the access can go ahead. For each request the block also reports the unloaded service latency in DRAM clocks. It keeps running per-class totals, and software derives the hit, miss and conflict ratios from them.

Requests arrive already decoded into channel, rank, bank and row fields, with a read/write flag, and are accepted with a valid/ready handshake. Bank state is kept per conceptual bank. A rank holds eight banks, and one bank index names the same bank in every chip of that rank. An adaptive page policy closes a bank's open row after a programmable number of later requests that go to other banks. All four timing values (row activate, column access, precharge and burst) are programmable cycle counts. The package supplies defaults that match 13.5 ns for activate, column access and precharge and 6 ns for a burst, at an 800 MHz DRAM clock.

Top module: `rowbuf_classifier`

## Requirements
- R1: A request whose bank has the requested row open is classed as a hit, with `res_class` = 0, and its latency is `cfg_t_cas + cfg_t_burst`.
- R2: A request whose bank has no open row is classed as a miss, with `res_class` = 1, and its latency is `cfg_t_rcd + cfg_t_cas + cfg_t_burst`.
- R3: A request whose bank has a different row open is classed as a conflict, with `res_class` = 2, and its latency is `cfg_t_rp + cfg_t_rcd + cfg_t_cas + cfg_t_burst`. After a conflict, and also after a miss, the bank keeps the newly requested row open.
- R4: Every accepted request to another bank advances an open bank's idle count. When that count reaches `cfg_close_after`, the bank is closed, so its next access is a miss. A value of 0 behaves like 1. Any access to the bank clears its idle count.
- R5: State is held separately for each {channel, rank, bank} triple. A bank with the same index in a different rank or channel does not share a row buffer with it.
- R6: After reset every bank is closed, so the first access to any bank is a miss, and all three counters read zero.
- R7: `cnt_hit`, `cnt_miss` and `cnt_conf` each count results of their own class. Exactly one of them goes up by 1 in the cycle a result is presented, and none changes otherwise.
- R8: `req_ready` is high whenever reset is low. An accepted request produces `res_valid` for exactly one cycle, on the clock edge after acceptance. The read/write flag does not affect the class or the latency.
- R9: Timing values and the close count are sampled at the acceptance edge, so a change applies to the next request that is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_chan | input | CHAN_W | Channel field |
| req_rank | input | RANK_W | Rank field |
| req_bank | input | BANK_W | Bank index within the rank |
| req_row | input | ROW_W | Row address |
| req_write | input | 1 | 1 for write, 0 for read |
| cfg_t_rcd | input | TIME_W | Row activate time in cycles |
| cfg_t_cas | input | TIME_W | Column access time in cycles |
| cfg_t_rp | input | TIME_W | Precharge time in cycles |
| cfg_t_burst | input | TIME_W | Data burst time in cycles |
| cfg_close_after | input | CLOSE_W | Idle requests before auto-close |
| res_valid | output | 1 | Classification result present |
| res_class | output | 2 | 0 hit, 1 miss, 2 conflict |
| res_latency | output | TIME_W+2 | Unloaded service latency in cycles |
| cnt_hit | output | CNT_W | Running hit total |
| cnt_miss | output | CNT_W | Running miss total |
| cnt_conf | output | CNT_W | Running conflict total |

## Verification
The assertions check on every cycle the rules that follow from the ports alone. Each latency must match the timing sum for its reported class, using the settings present at acceptance. A result must appear one cycle after each accepted request. The class code must be legal. Exactly one counter must step with each result, and all counters must be zero after reset. Whether the class itself is right depends on the history of accesses to each bank: the row left open, the banks kept apart by rank and channel, and the count of other-bank requests before auto-close. Only the bench's directed sequences can show these, because they compare results against access histories chosen by hand.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

    typedef enum logic [1:0] {
        CLS_HIT  = 2'd0,
        CLS_MISS = 2'd1,
        CLS_CONF = 2'd2
    } rbc_class_e;

    // Defaults at an 800 MHz DRAM clock: 13.5 ns -> 11 cycles, 6 ns -> 5 cycles
    localparam int DEF_T_RCD   = 11;
    localparam int DEF_T_CAS   = 11;
    localparam int DEF_T_RP    = 11;
    localparam int DEF_T_BURST = 5;
    localparam int DEF_CLOSE   = 4;

    function automatic int field_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rbc_bank_table.sv
module rbc_bank_table
    import rbc_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int ROW_W   = 14,
    parameter int CLOSE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   lk_idx,
    input  logic [ROW_W-1:0]   lk_row,
    input  logic               upd_en,
    input  logic [CLOSE_W-1:0] close_after,
    output rbc_class_e         lk_class
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] open_q;
    logic [ROW_W-1:0]   row_q  [ENTRIES];
    logic [CLOSE_W-1:0] idle_q [ENTRIES];

    always_comb begin
        if (!open_q[lk_idx])
            lk_class = CLS_MISS;
        else if (row_q[lk_idx] == lk_row)
            lk_class = CLS_HIT;
        else
            lk_class = CLS_CONF;
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_bank
        logic [CLOSE_W:0] idle_next;
        assign idle_next = {1'b0, idle_q[e]} + 1'b1;

        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[e] <= 1'b0;
                row_q[e]  <= '0;
                idle_q[e] <= '0;
            end else if (upd_en) begin
                if (lk_idx == IDX_W'(e)) begin
                    open_q[e] <= 1'b1;
                    row_q[e]  <= lk_row;
                    idle_q[e] <= '0;
                end else if (open_q[e]) begin
                    if (idle_next >= {1'b0, close_after}) begin
                        open_q[e] <= 1'b0;
                        idle_q[e] <= '0;
                    end else begin
                        idle_q[e] <= idle_next[CLOSE_W-1:0];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rbc_latency.sv
module rbc_latency
    import rbc_pkg::*;
#(
    parameter int TIME_W = 6
) (
    input  rbc_class_e          cls,
    input  logic [TIME_W-1:0]   t_rcd,
    input  logic [TIME_W-1:0]   t_cas,
    input  logic [TIME_W-1:0]   t_rp,
    input  logic [TIME_W-1:0]   t_burst,
    output logic [TIME_W+1:0]   latency
);
    localparam int LAT_W = TIME_W + 2;

    logic [LAT_W-1:0] base;
    assign base = LAT_W'(t_cas) + LAT_W'(t_burst);

    always_comb begin
        unique case (cls)
            CLS_HIT:  latency = base;
            CLS_MISS: latency = base + LAT_W'(t_rcd);
            default:  latency = base + LAT_W'(t_rcd) + LAT_W'(t_rp);
        endcase
    end
endmodule

// File: rtl/rbc_counters.sv
module rbc_counters
    import rbc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev,
    input  rbc_class_e       cls,
    output logic [CNT_W-1:0] totals [3]
);
    for (genvar c = 0; c < 3; c++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)
                totals[c] <= '0;
            else if (ev && (cls == rbc_class_e'(c)))
                totals[c] <= totals[c] + 1'b1;
        end
    end
endmodule

// File: rtl/rowbuf_classifier.sv
module rowbuf_classifier
    import rbc_pkg::*;
#(
    parameter int NCHAN          = 2,
    parameter int NRANK          = 2,
    parameter int BANKS_PER_RANK = 8,
    parameter int ROW_W          = 14,
    parameter int TIME_W         = 6,
    parameter int CLOSE_W        = 4,
    parameter int CNT_W          = 32,
    localparam int CHAN_W = field_w(NCHAN),
    localparam int RANK_W = field_w(NRANK),
    localparam int BANK_W = field_w(BANKS_PER_RANK)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [CHAN_W-1:0]   req_chan,
    input  logic [RANK_W-1:0]   req_rank,
    input  logic [BANK_W-1:0]   req_bank,
    input  logic [ROW_W-1:0]    req_row,
    input  logic                req_write,
    input  logic [TIME_W-1:0]   cfg_t_rcd,
    input  logic [TIME_W-1:0]   cfg_t_cas,
    input  logic [TIME_W-1:0]   cfg_t_rp,
    input  logic [TIME_W-1:0]   cfg_t_burst,
    input  logic [CLOSE_W-1:0]  cfg_close_after,
    output logic                res_valid,
    output logic [1:0]          res_class,
    output logic [TIME_W+1:0]   res_latency,
    output logic [CNT_W-1:0]    cnt_hit,
    output logic [CNT_W-1:0]    cnt_miss,
    output logic [CNT_W-1:0]    cnt_conf
);
    localparam int IDX_W = CHAN_W + RANK_W + BANK_W;

    logic               accept;
    logic [IDX_W-1:0]   idx;
    rbc_class_e         cls_now;
    logic [TIME_W+1:0]  lat_now;
    logic [CNT_W-1:0]   totals [3];
    logic               write_unused;

    assign req_ready    = !rst;
    assign accept       = req_valid && req_ready;
    assign idx          = {req_chan, req_rank, req_bank};
    assign write_unused = req_write;

    rbc_bank_table #(.IDX_W(IDX_W), .ROW_W(ROW_W), .CLOSE_W(CLOSE_W)) u_table (
        .clk(clk), .rst(rst), .lk_idx(idx), .lk_row(req_row),
        .upd_en(accept), .close_after(cfg_close_after), .lk_class(cls_now)
    );

    rbc_latency #(.TIME_W(TIME_W)) u_lat (
        .cls(cls_now), .t_rcd(cfg_t_rcd), .t_cas(cfg_t_cas),
        .t_rp(cfg_t_rp), .t_burst(cfg_t_burst), .latency(lat_now)
    );

    rbc_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .ev(accept), .cls(cls_now), .totals(totals)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_class   <= CLS_MISS;
            res_latency <= '0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                res_class   <= cls_now;
                res_latency <= lat_now;
            end
        end
    end

    assign cnt_hit  = totals[0];
    assign cnt_miss = totals[1];
    assign cnt_conf = totals[2];
endmodule

// File: rtl/rbc_checker.sv
module rbc_checker #(
    parameter int TIME_W = 6,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [TIME_W-1:0] cfg_t_rcd,
    input logic [TIME_W-1:0] cfg_t_cas,
    input logic [TIME_W-1:0] cfg_t_rp,
    input logic [TIME_W-1:0] cfg_t_burst,
    input logic              res_valid,
    input logic [1:0]        res_class,
    input logic [TIME_W+1:0] res_latency,
    input logic [CNT_W-1:0]  cnt_hit,
    input logic [CNT_W-1:0]  cnt_miss,
    input logic [CNT_W-1:0]  cnt_conf
);
    localparam int LAT_W = TIME_W + 2;

    logic [LAT_W-1:0] sum_hit, sum_miss, sum_conf;
    assign sum_hit  = LAT_W'(cfg_t_cas) + LAT_W'(cfg_t_burst);
    assign sum_miss = sum_hit + LAT_W'(cfg_t_rcd);
    assign sum_conf = sum_miss + LAT_W'(cfg_t_rp);

    a_r1_hit_latency: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_class == 2'd0) |-> res_latency == $past(sum_hit));

    a_r2_miss_latency: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_class == 2'd1) |-> res_latency == $past(sum_miss));

    a_r3_conf_latency: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_class == 2'd2) |-> res_latency == $past(sum_conf));

    a_r3_class_legal: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_class != 2'd3);

    a_r6_counters_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt_hit == '0 && cnt_miss == '0 && cnt_conf == '0));

    a_r7_one_step: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !$past(rst)) |->
        (cnt_hit + cnt_miss + cnt_conf) == ($past(cnt_hit) + $past(cnt_miss) + $past(cnt_conf) + 1'b1));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!res_valid && !$past(rst)) |->
        ($stable(cnt_hit) && $stable(cnt_miss) && $stable(cnt_conf)));

    a_r8_result_timing: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (res_valid == $past(req_valid && req_ready)));

    a_r8_ready: assert property (@(posedge clk) disable iff (rst) req_ready);
endmodule

bind rowbuf_classifier rbc_checker #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .cfg_t_rcd(cfg_t_rcd), .cfg_t_cas(cfg_t_cas), .cfg_t_rp(cfg_t_rp),
    .cfg_t_burst(cfg_t_burst), .res_valid(res_valid), .res_class(res_class),
    .res_latency(res_latency), .cnt_hit(cnt_hit), .cnt_miss(cnt_miss),
    .cnt_conf(cnt_conf)
);

// File: tb/rowbuf_classifier_test.sv
`timescale 1ns/1ps
module rowbuf_classifier_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [0:0]  req_chan = '0;
    logic [0:0]  req_rank = '0;
    logic [2:0]  req_bank = '0;
    logic [13:0] req_row = '0;
    logic        req_write = 1'b0;
    logic [5:0]  cfg_t_rcd = 6'd11, cfg_t_cas = 6'd11, cfg_t_rp = 6'd11, cfg_t_burst = 6'd5;
    logic [3:0]  cfg_close_after = 4'd4;
    logic        res_valid;
    logic [1:0]  res_class;
    logic [7:0]  res_latency;
    logic [31:0] cnt_hit, cnt_miss, cnt_conf;

    int checks = 0, fails = 0;
    int e_hit = 0, e_miss = 0, e_conf = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rowbuf_classifier uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_rank(req_rank), .req_bank(req_bank),
        .req_row(req_row), .req_write(req_write),
        .cfg_t_rcd(cfg_t_rcd), .cfg_t_cas(cfg_t_cas), .cfg_t_rp(cfg_t_rp),
        .cfg_t_burst(cfg_t_burst), .cfg_close_after(cfg_close_after),
        .res_valid(res_valid), .res_class(res_class), .res_latency(res_latency),
        .cnt_hit(cnt_hit), .cnt_miss(cnt_miss), .cnt_conf(cnt_conf)
    );

    task automatic check_eq(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        check_eq("R8 ready low in reset", req_ready, 0);
        @(negedge clk);
        rst = 1'b0;
        e_hit = 0; e_miss = 0; e_conf = 0;
        @(negedge clk);
    endtask

    // class: 0 hit, 1 miss, 2 conflict (R1..R3)
    task automatic send(input int ch, input int rk, input int bk, input int row,
                        input bit wr, input int exp_cls, input string tag);
        int exp_lat;
        req_chan = 1'(ch); req_rank = 1'(rk); req_bank = 3'(bk);
        req_row = 14'(row); req_write = wr; req_valid = 1'b1;
        exp_lat = cfg_t_cas + cfg_t_burst;
        if (exp_cls >= 1) exp_lat += cfg_t_rcd;
        if (exp_cls == 2) exp_lat += cfg_t_rp;
        if (exp_cls == 0) e_hit++; else if (exp_cls == 1) e_miss++; else e_conf++;
        @(negedge clk);
        req_valid = 1'b0;
        check_eq({tag, " R8 valid"}, res_valid, 1);
        check_eq({tag, " class"}, res_class, exp_cls);
        check_eq({tag, " latency"}, res_latency, exp_lat);
        check_eq({tag, " R7 hits"}, cnt_hit, e_hit);
        check_eq({tag, " R7 misses"}, cnt_miss, e_miss);
        check_eq({tag, " R7 conflicts"}, cnt_conf, e_conf);
    endtask

    task automatic t_reset_state();
        do_reset();
        check_eq("R6 hit count zero", cnt_hit, 0);
        check_eq("R6 miss count zero", cnt_miss, 0);
        check_eq("R6 conf count zero", cnt_conf, 0);
        check_eq("R8 no result idle", res_valid, 0);
        check_eq("R8 ready after reset", req_ready, 1);
    endtask

    task automatic t_basic_classes();
        do_reset();
        send(0, 0, 2, 5, 0, 1, "R6 first access miss R2");
        send(0, 0, 2, 5, 0, 0, "R1 same row hit");
        send(0, 0, 2, 5, 1, 0, "R8 write hit unaffected");
        check_eq("R8 single result pulse", res_valid, 1);
        @(negedge clk);
        check_eq("R8 result pulse ends", res_valid, 0);
        send(0, 0, 2, 9, 1, 2, "R3 other row conflict");
        send(0, 0, 2, 9, 0, 0, "R3 new row left open");
    endtask

    task automatic t_bank_isolation();
        do_reset();
        send(0, 0, 3, 7, 0, 1, "R5 ch0 rk0 b3 miss");
        send(0, 1, 3, 7, 0, 1, "R5 other rank same index miss");
        send(1, 0, 3, 7, 0, 1, "R5 other channel same index miss");
        send(0, 0, 3, 7, 0, 0, "R5 original bank still open");
        send(0, 0, 4, 7, 0, 1, "R5 neighbour bank miss");
        send(0, 1, 3, 7, 0, 0, "R5 other rank kept own row");
    endtask

    task automatic t_auto_close();
        do_reset();
        send(0, 0, 0, 1, 0, 1, "R4 open A");
        for (int b = 1; b <= 3; b++) send(1, 1, b, 2, 0, 1, "R4 other bank");
        send(0, 0, 0, 1, 0, 0, "R4 three idle still hit");
        for (int b = 4; b <= 7; b++) send(1, 1, b, 2, 0, 1, "R4 other bank");
        send(0, 0, 0, 1, 0, 1, "R4 four idle closes to miss");
        send(0, 0, 0, 3, 0, 2, "R4 reopened row conflicts");
    endtask

    task automatic t_idle_cleared();
        do_reset();
        send(0, 1, 6, 4, 0, 1, "R4 open B");
        for (int b = 0; b <= 2; b++) send(1, 0, b, 8, 0, 1, "R4 filler");
        send(0, 1, 6, 4, 0, 0, "R4 access clears idle");
        for (int b = 3; b <= 5; b++) send(1, 0, b, 8, 0, 1, "R4 filler");
        send(0, 1, 6, 4, 0, 0, "R4 still open after six total");
    endtask

    task automatic t_program_close();
        do_reset();
        cfg_close_after = 4'd2;
        send(1, 1, 0, 11, 0, 1, "R9 open C");
        send(0, 0, 1, 11, 0, 1, "R9 filler");
        send(1, 1, 0, 11, 0, 0, "R9 one idle hit");
        send(0, 0, 1, 11, 0, 0, "R9 filler hit");
        send(0, 0, 2, 11, 0, 1, "R9 filler");
        send(1, 1, 0, 11, 0, 1, "R9 close after two");
        cfg_close_after = 4'd4;
    endtask

    task automatic t_timing();
        do_reset();
        cfg_t_cas = 6'd3; cfg_t_burst = 6'd2; cfg_t_rcd = 6'd7; cfg_t_rp = 6'd9;
        send(0, 0, 5, 20, 0, 1, "R9 R2 new miss latency");
        send(0, 0, 5, 20, 0, 0, "R9 R1 new hit latency");
        send(0, 0, 5, 21, 0, 2, "R9 R3 new conflict latency");
        cfg_t_cas = 6'd11; cfg_t_burst = 6'd5; cfg_t_rcd = 6'd11; cfg_t_rp = 6'd11;
        send(0, 0, 5, 21, 0, 0, "R9 restored hit latency");
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_basic_classes();
        t_bank_isolation();
        t_auto_close();
        t_idle_cleared();
        t_program_close();
        t_timing();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule